// File: doc/BRIEF.md
# Nibble-wide framed cell port

This block serves one port of a 4-bit cell path in both directions. Toward the line it keeps one cell per direction. On the transmit side it gives the attached device a per-cycle transfer enable, taken from the free-running block clock. The enable is high only while the port can take another nibble. A one-cycle start pulse from the device marks the start of a cell, and the 106 nibbles that follow on enabled cycles fill the transmit cell store. The line side then empties that store one byte at a time.

On the receive side the line side writes a 53-byte cell into the receive store. The attached device pulses a ready strobe each time it wants the next nibble. On the first strobe after a cell is complete, the port raises a one-cycle start pulse. Each later strobe presents the next nibble. Between strobes the nibble output holds its value. Each direction has its own bus.

Top module: `nibble_cell_port`

## Requirements
- R1: After reset `tx_strobe` and `line_rx_room` are 1; `tx_frame_err`, `line_tx_valid`, `rx_frame` are 0 and `rx_nib` is 0.
- R2: Once a transmit cell is complete, `tx_strobe` is 0 and `line_tx_valid` is 1 in the cycle after the last nibble is accepted. They stay so until the last byte is taken with `line_tx_take`, and `tx_strobe` is 1 in the cycle after that.
- R3: `tx_frame` high on an enabled cycle starts a cell, and the nibble on the next enabled cycle is nibble 0. Nibbles that arrive while no cell has been started are ignored and buffer nothing.
- R4: A cell is 53 bytes in 106 nibbles, high nibble (bits 7:4) of each byte first. Bytes appear on `line_tx_byte` in arrival order, with `line_tx_first` high only on byte 0.
- R5: `tx_frame` after 1 to 105 nibbles of a cell discards the partial cell and pulses `tx_frame_err` for exactly one cycle, in the cycle after. The pulse re-starts collection, so the next 106 nibbles form a full cell.
- R6: Repeated `tx_frame` pulses before any nibble of the cell just re-start it without an error.
- R7: While `tx_strobe` is 0, `tx_frame` and `tx_nib` are ignored.
- R8: `line_rx_valid` writes one byte while `line_rx_room` is 1. After 53 bytes `line_rx_room` drops to 0, and further writes are ignored.
- R9: The first `rx_rdy` with a complete receive cell raises `rx_frame` for exactly one cycle, with `rx_nib` 0. Each later `rx_rdy` presents the next nibble, high nibble first, in the cycle after the strobe. `rx_nib` holds between strobes.
- R10: An `rx_rdy` with no complete cell raises no `rx_frame`, and `rx_nib` reads 0.
- R11: In the cycle after the strobe that presents nibble 105, `line_rx_room` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_strobe | output | 1 | Transfer enable: port takes a nibble this cycle |
| tx_frame | input | 1 | Start pulse one enabled cycle before nibble 0 |
| tx_nib | input | NIB_W | Transmit nibble from the device |
| tx_frame_err | output | 1 | One-cycle pulse on a cut-short cell |
| line_tx_valid | output | 1 | A complete transmit cell is buffered |
| line_tx_first | output | 1 | Current byte is byte 0 of the cell |
| line_tx_byte | output | 2*NIB_W | Current transmit byte |
| line_tx_take | input | 1 | Line side consumes the current byte |
| line_rx_valid | input | 1 | Line side writes a receive byte |
| line_rx_byte | input | 2*NIB_W | Receive byte |
| line_rx_room | output | 1 | Receive store can accept bytes |
| rx_rdy | input | 1 | Device ready strobe for the next nibble |
| rx_frame | output | 1 | One-cycle receive start pulse |
| rx_nib | output | NIB_W | Receive nibble to the device |

## Verification
The assertions assume that the device drives nibbles back to back on enabled cycles once a cell has started. They also assume that the line side writes the receive store only while room is shown and consumes transmit bytes only while valid is high. Within those limits, the bench draws random cell contents, random take gaps and random ready-strobe spacing. It also places deliberate stray frames and nibbles in the windows where the port must ignore them, and the checks at the ports expose any effect those inputs have.

// File: rtl/nibble_port_pkg.sv
package nibble_port_pkg;

   typedef enum logic [1:0] {
      TX_IDLE    = 2'd0,
      TX_ARMED   = 2'd1,
      TX_COLLECT = 2'd2
   } tx_state_t;

   function automatic int nibbles_per_cell(input int units);
      return 2 * units;
   endfunction

endpackage

// File: rtl/nib_cell_store.sv
module nib_cell_store #(
   parameter int W     = 8,
   parameter int DEPTH = 53,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);
   logic [W-1:0] mem [DEPTH];

   initial assert (DEPTH >= 2) else $error("store depth too small");

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nib_tx_collect.sv
module nib_tx_collect
   import nibble_port_pkg::*;
#(
   parameter int NIB_W      = 4,
   parameter int CELL_UNITS = 53,
   parameter bit HI_FIRST   = 1'b1,
   parameter int AW         = $clog2(CELL_UNITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic                 tx_strobe,
   input  logic                 tx_frame,
   input  logic [NIB_W-1:0]     tx_nib,
   output logic                 tx_frame_err,
   output logic                 wr_en,
   output logic [AW-1:0]        wr_addr,
   output logic [2*NIB_W-1:0]   wr_data,
   output logic [AW-1:0]        rd_addr,
   input  logic                 take,
   output logic                 full
);
   localparam int NIBS = nibbles_per_cell(CELL_UNITS);
   localparam int CW   = $clog2(NIBS + 1);

   tx_state_t        st;
   logic [CW-1:0]    cnt;
   logic [NIB_W-1:0] hold;
   logic             full_q;
   logic [AW-1:0]    rd_q;
   logic             err_q;
   logic             accept_nib;

   assign tx_strobe    = !full_q;
   assign full         = full_q;
   assign rd_addr      = rd_q;
   assign tx_frame_err = err_q;
   assign accept_nib   = tx_strobe && !tx_frame && (st != TX_IDLE);
   assign wr_en        = accept_nib && cnt[0];
   assign wr_addr      = AW'(cnt >> 1);

   generate
      if (HI_FIRST) begin : g_hi_first
         assign wr_data = {hold, tx_nib};
      end else begin : g_lo_first
         assign wr_data = {tx_nib, hold};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= TX_IDLE;
         cnt    <= '0;
         hold   <= '0;
         full_q <= 1'b0;
         rd_q   <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (tx_strobe) begin
            if (tx_frame) begin
               if (st == TX_COLLECT) err_q <= 1'b1;
               st  <= TX_ARMED;
               cnt <= '0;
            end else if (st != TX_IDLE) begin
               if (!cnt[0]) hold <= tx_nib;
               if (cnt == CW'(NIBS - 1)) begin
                  full_q <= 1'b1;
                  st     <= TX_IDLE;
                  cnt    <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
                  st  <= TX_COLLECT;
               end
            end
         end
         if (full_q && take) begin
            if (rd_q == AW'(CELL_UNITS - 1)) begin
               rd_q   <= '0;
               full_q <= 1'b0;
            end else begin
               rd_q <= rd_q + 1'b1;
            end
         end
      end
   end

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(NIBS));

   assert_full_after_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q) |-> ($past(st) == TX_COLLECT) && ($past(cnt) == CW'(NIBS - 1)));

   assert_err_mid_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> ($past(st) == TX_COLLECT) && $past(tx_frame));

   assert_frozen_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(full_q) && full_q) |-> ($stable(hold) && (cnt == '0) && (st == TX_IDLE)));
endmodule

// File: rtl/nib_rx_present.sv
module nib_rx_present #(
   parameter int NIB_W      = 4,
   parameter int CELL_UNITS = 53,
   parameter bit HI_FIRST   = 1'b1,
   parameter int AW         = $clog2(CELL_UNITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_rx_valid,
   output logic                 line_rx_room,
   output logic                 wr_en,
   output logic [AW-1:0]        wr_addr,
   output logic [AW-1:0]        rd_addr,
   input  logic [2*NIB_W-1:0]   rd_data,
   input  logic                 rx_rdy,
   output logic                 rx_frame,
   output logic [NIB_W-1:0]     rx_nib
);
   localparam int NIBS = nibbles_per_cell_l(CELL_UNITS);
   localparam int CW   = $clog2(NIBS + 1);

   function automatic int nibbles_per_cell_l(input int units);
      return 2 * units;
   endfunction

   logic             full_q;
   logic [AW-1:0]    widx;
   logic             sending;
   logic [CW-1:0]    nidx;
   logic             frame_q;
   logic [NIB_W-1:0] nib_q;
   logic [NIB_W-1:0] sel;

   assign line_rx_room = !full_q;
   assign wr_en        = line_rx_valid && !full_q;
   assign wr_addr      = widx;
   assign rd_addr      = AW'(nidx >> 1);
   assign rx_frame     = frame_q;
   assign rx_nib       = nib_q;

   generate
      if (HI_FIRST) begin : g_hi_first
         assign sel = nidx[0] ? rd_data[NIB_W-1:0] : rd_data[2*NIB_W-1:NIB_W];
      end else begin : g_lo_first
         assign sel = nidx[0] ? rd_data[2*NIB_W-1:NIB_W] : rd_data[NIB_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         widx    <= '0;
         sending <= 1'b0;
         nidx    <= '0;
         frame_q <= 1'b0;
         nib_q   <= '0;
      end else begin
         if (wr_en) begin
            if (widx == AW'(CELL_UNITS - 1)) begin
               widx   <= '0;
               full_q <= 1'b1;
            end else begin
               widx <= widx + 1'b1;
            end
         end
         frame_q <= 1'b0;
         if (rx_rdy) begin
            if (!sending) begin
               nib_q <= '0;
               if (full_q) begin
                  frame_q <= 1'b1;
                  sending <= 1'b1;
                  nidx    <= '0;
               end
            end else begin
               nib_q <= sel;
               if (nidx == CW'(NIBS - 1)) begin
                  sending <= 1'b0;
                  full_q  <= 1'b0;
                  nidx    <= '0;
               end else begin
                  nidx <= nidx + 1'b1;
               end
            end
         end
      end
   end

   assert_frame_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_q |=> !frame_q);

   assert_frame_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_q |-> $past(rx_rdy) && $past(full_q) && !$past(sending));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rdy && !full_q && !sending) |=> (nib_q == '0) && !frame_q);

   assert_read_needs_cell_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sending |-> full_q);
endmodule

// File: rtl/nibble_cell_port.sv
module nibble_cell_port #(
   parameter int NIB_W      = 4,
   parameter int CELL_UNITS = 53,
   parameter bit HI_FIRST   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic                 tx_strobe,
   input  logic                 tx_frame,
   input  logic [NIB_W-1:0]     tx_nib,
   output logic                 tx_frame_err,
   output logic                 line_tx_valid,
   output logic                 line_tx_first,
   output logic [2*NIB_W-1:0]   line_tx_byte,
   input  logic                 line_tx_take,
   input  logic                 line_rx_valid,
   input  logic [2*NIB_W-1:0]   line_rx_byte,
   output logic                 line_rx_room,
   input  logic                 rx_rdy,
   output logic                 rx_frame,
   output logic [NIB_W-1:0]     rx_nib
);
   localparam int UNIT_W = 2 * NIB_W;
   localparam int AW     = $clog2(CELL_UNITS);

   initial assert (NIB_W >= 1 && CELL_UNITS >= 2) else $error("bad port geometry");

   logic              t_wr_en;
   logic [AW-1:0]     t_wr_addr;
   logic [UNIT_W-1:0] t_wr_data;
   logic [AW-1:0]     t_rd_addr;
   logic              t_full;

   logic              r_wr_en;
   logic [AW-1:0]     r_wr_addr;
   logic [AW-1:0]     r_rd_addr;
   logic [UNIT_W-1:0] r_rd_data;

   nib_tx_collect #(.NIB_W(NIB_W), .CELL_UNITS(CELL_UNITS), .HI_FIRST(HI_FIRST), .AW(AW)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_strobe    (tx_strobe),
      .tx_frame     (tx_frame),
      .tx_nib       (tx_nib),
      .tx_frame_err (tx_frame_err),
      .wr_en        (t_wr_en),
      .wr_addr      (t_wr_addr),
      .wr_data      (t_wr_data),
      .rd_addr      (t_rd_addr),
      .take         (line_tx_take),
      .full         (t_full)
   );

   nib_cell_store #(.W(UNIT_W), .DEPTH(CELL_UNITS), .AW(AW)) u_tx_store (
      .clk     (clk),
      .wr_en   (t_wr_en),
      .wr_addr (t_wr_addr),
      .wr_data (t_wr_data),
      .rd_addr (t_rd_addr),
      .rd_data (line_tx_byte)
   );

   assign line_tx_valid = t_full;
   assign line_tx_first = t_full && (t_rd_addr == '0);

   nib_rx_present #(.NIB_W(NIB_W), .CELL_UNITS(CELL_UNITS), .HI_FIRST(HI_FIRST), .AW(AW)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .line_rx_valid (line_rx_valid),
      .line_rx_room  (line_rx_room),
      .wr_en         (r_wr_en),
      .wr_addr       (r_wr_addr),
      .rd_addr       (r_rd_addr),
      .rd_data       (r_rd_data),
      .rx_rdy        (rx_rdy),
      .rx_frame      (rx_frame),
      .rx_nib        (rx_nib)
   );

   nib_cell_store #(.W(UNIT_W), .DEPTH(CELL_UNITS), .AW(AW)) u_rx_store (
      .clk     (clk),
      .wr_en   (r_wr_en),
      .wr_addr (r_wr_addr),
      .wr_data (line_rx_byte),
      .rd_addr (r_rd_addr),
      .rd_data (r_rd_data)
   );
endmodule

// File: tb/test_nibble_cell_port.sv
module test_nibble_cell_port;
   localparam int CELLB = 53;
   localparam int NIBS  = 106;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_frame = 1'b0;
   logic [3:0] tx_nib = '0;
   logic       line_tx_take = 1'b0;
   logic       line_rx_valid = 1'b0;
   logic [7:0] line_rx_byte = '0;
   logic       rx_rdy = 1'b0;
   logic       tx_strobe, tx_frame_err, line_tx_valid, line_tx_first, line_rx_room, rx_frame;
   logic [7:0] line_tx_byte;
   logic [3:0] rx_nib;

   int checks = 0;
   int errors = 0;
   logic [7:0] cur [CELLB];

   always #4 clk = ~clk;

   nibble_cell_port i_nibble_cell_port (
      .clk(clk), .rst_n(rst_n),
      .tx_strobe(tx_strobe), .tx_frame(tx_frame), .tx_nib(tx_nib), .tx_frame_err(tx_frame_err),
      .line_tx_valid(line_tx_valid), .line_tx_first(line_tx_first), .line_tx_byte(line_tx_byte),
      .line_tx_take(line_tx_take),
      .line_rx_valid(line_rx_valid), .line_rx_byte(line_rx_byte), .line_rx_room(line_rx_room),
      .rx_rdy(rx_rdy), .rx_frame(rx_frame), .rx_nib(rx_nib)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [3:0] nib_at(input logic [7:0] b, input int k);
      return (k % 2 == 0) ? b[7:4] : b[3:0];
   endfunction

   task automatic fill_cell();
      for (int i = 0; i < CELLB; i++) cur[i] = 8'($urandom_range(0, 255));
   endtask

   task automatic push_nibbles();
      for (int k = 0; k < NIBS; k++) begin
         tx_nib = nib_at(cur[k / 2], k);
         step();
      end
   endtask

   task automatic tx_send();
      tx_frame = 1'b1;
      step();
      tx_frame = 1'b0;
      push_nibbles();
      chk(tx_strobe == 1'b0, "R2 strobe low when full", int'(tx_strobe), 0);
      chk(line_tx_valid == 1'b1, "R2 valid when full", int'(line_tx_valid), 1);
   endtask

   task automatic tx_drain(input string req);
      for (int i = 0; i < CELLB; i++) begin
         repeat ($urandom_range(0, 2)) step();
         chk(tx_strobe == 1'b0, "R2 strobe low while draining", int'(tx_strobe), 0);
         chk(line_tx_byte == cur[i], req, int'(line_tx_byte), int'(cur[i]));
         chk(line_tx_first == (i == 0), "R4 first flag", int'(line_tx_first), int'(i == 0));
         line_tx_take = 1'b1;
         step();
         line_tx_take = 1'b0;
      end
      chk(tx_strobe == 1'b1, "R2 strobe back after drain", int'(tx_strobe), 1);
      chk(line_tx_valid == 1'b0, "R2 valid clear after drain", int'(line_tx_valid), 0);
   endtask

   task automatic rx_write();
      for (int i = 0; i < CELLB; i++) begin
         repeat ($urandom_range(0, 2)) step();
         chk(line_rx_room == 1'b1, "R8 room while filling", int'(line_rx_room), 1);
         line_rx_valid = 1'b1;
         line_rx_byte  = cur[i];
         step();
         line_rx_valid = 1'b0;
      end
      chk(line_rx_room == 1'b0, "R8 room drops when full", int'(line_rx_room), 0);
      line_rx_valid = 1'b1;
      line_rx_byte  = ~cur[0];
      step();
      line_rx_valid = 1'b0;
   endtask

   task automatic rdy_pulse();
      rx_rdy = 1'b1;
      step();
      rx_rdy = 1'b0;
   endtask

   task automatic rx_read();
      logic [3:0] prev;
      rdy_pulse();
      chk(rx_frame == 1'b1, "R9 frame on first strobe", int'(rx_frame), 1);
      chk(rx_nib == 4'd0, "R9 nibble zero with frame", int'(rx_nib), 0);
      step();
      chk(rx_frame == 1'b0, "R9 frame one cycle", int'(rx_frame), 0);
      prev = 4'd0;
      for (int k = 0; k < NIBS; k++) begin
         for (int g = 0; g < int'($urandom_range(0, 3)); g++) begin
            step();
            chk(rx_nib == prev, "R9 nibble holds between strobes", int'(rx_nib), int'(prev));
         end
         rdy_pulse();
         chk(rx_nib == nib_at(cur[k / 2], k), "R9 nibble order", int'(rx_nib), int'(nib_at(cur[k / 2], k)));
         chk(rx_frame == 1'b0, "R9 no frame during cell", int'(rx_frame), 0);
         prev = rx_nib;
      end
      chk(line_rx_room == 1'b1, "R11 room returns", int'(line_rx_room), 1);
      rdy_pulse();
      chk(rx_frame == 1'b0, "R10 no frame when empty", int'(rx_frame), 0);
      chk(rx_nib == 4'd0, "R10 zero when empty", int'(rx_nib), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk(tx_strobe == 1'b1, "R1 strobe", int'(tx_strobe), 1);
      chk(line_rx_room == 1'b1, "R1 room", int'(line_rx_room), 1);
      chk(tx_frame_err == 1'b0, "R1 err", int'(tx_frame_err), 0);
      chk(line_tx_valid == 1'b0, "R1 valid", int'(line_tx_valid), 0);
      chk(rx_frame == 1'b0, "R1 rx frame", int'(rx_frame), 0);
      chk(rx_nib == 4'd0, "R1 rx nib", int'(rx_nib), 0);

      // R3: unframed nibbles ignored
      for (int i = 0; i < 12; i++) begin
         tx_nib = 4'($urandom_range(0, 15));
         step();
      end
      chk(line_tx_valid == 1'b0, "R3 no cell from unframed nibbles", int'(line_tx_valid), 0);
      fill_cell();
      tx_send();
      tx_drain("R3 framed cell contents");

      // R5: early frame discards partial cell
      fill_cell();
      tx_frame = 1'b1;
      step();
      tx_frame = 1'b0;
      for (int i = 0; i < 40; i++) begin
         tx_nib = 4'($urandom_range(0, 15));
         step();
      end
      tx_frame = 1'b1;
      step();
      tx_frame = 1'b0;
      chk(tx_frame_err == 1'b1, "R5 error pulse", int'(tx_frame_err), 1);
      chk(line_tx_valid == 1'b0, "R5 partial discarded", int'(line_tx_valid), 0);
      push_nibbles();
      chk(tx_frame_err == 1'b0, "R5 error one cycle", int'(tx_frame_err), 0);
      chk(line_tx_valid == 1'b1, "R5 next cell accepted", int'(line_tx_valid), 1);
      tx_drain("R5 cell after error");

      // R6: repeated frames before data
      fill_cell();
      for (int i = 0; i < 3; i++) begin
         tx_frame = 1'b1;
         step();
         chk(tx_frame_err == 1'b0, "R6 no error on re-frame", int'(tx_frame_err), 0);
      end
      tx_frame = 1'b0;
      push_nibbles();
      tx_drain("R6 cell after re-frames");

      // R7: inputs ignored while strobe low
      fill_cell();
      tx_send();
      for (int i = 0; i < 20; i++) begin
         tx_frame = (i % 5 == 0);
         tx_nib   = 4'($urandom_range(0, 15));
         step();
         chk(tx_frame_err == 1'b0, "R7 no error while full", int'(tx_frame_err), 0);
      end
      tx_frame = 1'b0;
      tx_drain("R7 buffered cell untouched");
      push_nibbles();
      chk(line_tx_valid == 1'b0, "R7 frame while full did not arm", int'(line_tx_valid), 0);

      // R4: random cells
      for (int c = 0; c < 3; c++) begin
         fill_cell();
         tx_send();
         tx_drain("R4 byte order");
      end

      // R10: strobe with empty receive store
      rdy_pulse();
      chk(rx_frame == 1'b0, "R10 no frame at start", int'(rx_frame), 0);
      chk(rx_nib == 4'd0, "R10 zero at start", int'(rx_nib), 0);

      // R8, R9, R11: receive cells
      for (int c = 0; c < 3; c++) begin
         fill_cell();
         rx_write();
         rx_read();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule